// File: doc/BRIEF.md
# Prescaled Interrupt Timer

This block is an 8-bit interrupt timer that counts upward from a reloadable start value and raises a level interrupt each time it wraps past its maximum. It has two counting modes. In cycle mode the counter advances on every enabled CPU cycle. In line mode a signed prescaler turns CPU cycles into an approximate video line rate. The prescaler loses 3 units per CPU cycle from a period of 341, and the counter advances once each time the prescaler runs out.

Software reaches the block through a small write port with a two-bit sub-address. That port holds the reload value, which is written as two nibbles, a three-bit control word, and an acknowledge location. A gate input from the surrounding controller allows counting only while the controller runs in the mode that owns this timer. Writes are still taken while the gate is low.

Top module: `irq_tick_timer`

## Requirements
- R1: At reset every register (reload value, control, counter, prescaler) and the irq output are zero.
- R2: A write with sub-address 0 puts wr_data[3:0] into reload bits [3:0]. A write with sub-address 1 puts wr_data[3:0] into reload bits [7:4].
- R3: A write with sub-address 2 stores wr_data[2:0] as the control word and clears irq. Control bit 0 is re-enable, bit 1 is enable and bit 2 is cycle mode. When wr_data[1] is 1, the same write also loads the counter from the reload value and sets the prescaler to 341.
- R4: A write with sub-address 3 clears irq and copies control bit 0 into control bit 1. It changes nothing else.
- R5: With enable and cycle mode both set, the counter advances by one on every cycle in which cyc_en and active are high.
- R6: With enable set and cycle mode clear, each counting cycle takes 3 from the prescaler. When the result is zero or below, 341 is added to it and the counter advances once.
- R7: An advance from 0xFF reloads the counter from the reload value and sets irq. irq then stays high until a write to sub-address 2 or 3.
- R8: The counter and the prescaler hold while active is low, cyc_en is low or enable is clear.
- R9: In a cycle with wr_en high, the counter and the prescaler do not advance, whatever the sub-address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cyc_en | input | 1 | One CPU cycle has elapsed this clock |
| active | input | 1 | Parent controller is in the mode that owns this timer |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register sub-address |
| wr_data | input | 8 | Write data |
| irq | output | 1 | Level interrupt request |

## Verification
The assertions assume that wr_sel and wr_data are meaningful whenever wr_en is high, and that the prescaler leaves reset at zero. Under those assumptions it always stays between 0 and 341. They make no assumption about how writes and counting cycles interleave. The stimulus therefore mixes writes to every sub-address with gated and ungated counting cycles in both modes. Directed sequences pin the exact wrap cycle in each mode, and they also cover the hold behaviour while gated or writing.

// File: rtl/irqt_pkg.sv
// Package for the prescaled interrupt timer.
// Holds the sub-address codes of the write port and the layout of the
// control word. The layout is fixed, because the write port decodes it.
package irqt_pkg;

    typedef enum logic [1:0] {
        SEL_RLD_LO = 2'd0,
        SEL_RLD_HI = 2'd1,
        SEL_CTRL   = 2'd2,
        SEL_ACK    = 2'd3
    } irqt_sel_e;

    // Control word: bit 2 cycle mode, bit 1 enable, bit 0 re-enable.
    typedef struct packed {
        logic cyc_mode;
        logic enable;
        logic reen;
    } irqt_ctrl_t;

    localparam int CTRL_W = $bits(irqt_ctrl_t);

endpackage

// File: rtl/irqt_regs.sv
// Write-port register file of the timer.
// It holds the reload value and the control word, and it produces a
// one-cycle load strobe and a one-cycle irq-clear strobe from the writes.
// Assumes wr_sel and wr_data are valid whenever wr_en is high.
module irqt_regs
    import irqt_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] rld_q,
    output irqt_ctrl_t       ctrl_q,
    output logic             load_p,
    output logic             clr_p
);
    localparam int HALF = CNT_W / 2;

    irqt_sel_e  sel;
    irqt_ctrl_t wr_ctrl;

    assign sel     = irqt_sel_e'(wr_sel);
    assign wr_ctrl = irqt_ctrl_t'(wr_data[CTRL_W-1:0]);

    // Decode the write strobes that reach the counter and the prescaler.
    always_comb begin
        load_p = wr_en && (sel == SEL_CTRL) && wr_ctrl.enable;
        clr_p  = wr_en && ((sel == SEL_CTRL) || (sel == SEL_ACK));
    end

    // Reload value: each nibble is written from the low nibble of the data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rld_q <= '0;
        end else if (wr_en && sel == SEL_RLD_LO) begin
            rld_q[HALF-1:0] <= wr_data[HALF-1:0];
        end else if (wr_en && sel == SEL_RLD_HI) begin
            rld_q[CNT_W-1:HALF] <= wr_data[CNT_W-HALF-1:0];
        end
    end

    // Control word: a full write, or an acknowledge that copies re-enable into enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_en && sel == SEL_CTRL) begin
            ctrl_q <= wr_ctrl;
        end else if (wr_en && sel == SEL_ACK) begin
            ctrl_q.enable <= ctrl_q.reen;
        end
    end

endmodule

// File: rtl/irqt_prescale.sv
// Line-rate prescaler.
// A signed register that loses STEP on each run cycle. When the result is
// zero or below, PERIOD is added back and wrap pulses for that cycle.
// Assumes PRE_W holds both PERIOD and -STEP.
module irqt_prescale #(
    parameter int PRE_W  = 10,
    parameter int PERIOD = 341,
    parameter int STEP   = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load,
    input  logic                    run,
    output logic signed [PRE_W-1:0] pre_q,
    output logic                    wrap
);
    localparam logic signed [PRE_W-1:0] STEP_S   = PRE_W'(STEP);
    localparam logic signed [PRE_W-1:0] PERIOD_S = PRE_W'(PERIOD);

    logic signed [PRE_W-1:0] diff;

    // Value after one step, and whether it has run out.
    always_comb begin
        diff = pre_q - STEP_S;
        wrap = run && (diff <= 0);
    end

    // Prescaler register: a load wins, otherwise step and wrap on run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (load) begin
            pre_q <= PERIOD_S;
        end else if (run) begin
            pre_q <= (diff <= 0) ? diff + PERIOD_S : diff;
        end
    end

endmodule

// File: rtl/irqt_counter.sv
// Up-counter with a reload on wrap and the level interrupt flag.
// Assumes load and clr never arrive in the same cycle as tick, because
// the parent suppresses ticks in write cycles.
module irqt_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             tick,
    input  logic             clr,
    input  logic [CNT_W-1:0] rld,
    output logic [CNT_W-1:0] cnt_q,
    output logic             irq_q
);
    logic at_top;

    // The counter is at its maximum value.
    assign at_top = (cnt_q == {CNT_W{1'b1}});

    // Counter: load from the reload value, or advance and reload on wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= rld;
        end else if (tick) begin
            cnt_q <= at_top ? rld : cnt_q + 1'b1;
        end
    end

    // Interrupt flag: set on wrap, cleared by a control or acknowledge write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else if (clr) begin
            irq_q <= 1'b0;
        end else if (tick && at_top) begin
            irq_q <= 1'b1;
        end
    end

endmodule

// File: rtl/irq_tick_timer.sv
// Top of the prescaled interrupt timer.
// Counts in cycle mode or line mode while the parent's gate is high and
// drives a level interrupt on wrap. A cycle that carries a write never
// counts. Assumes cyc_en marks exactly one CPU cycle per clock where high.
module irq_tick_timer
    import irqt_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int PRE_W  = 10,
    parameter int PERIOD = 341,
    parameter int STEP   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cyc_en,
    input  logic             active,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    output logic             irq
);
    logic [CNT_W-1:0]        rld_q;
    irqt_ctrl_t              ctrl_q;
    logic                    load_p;
    logic                    clr_p;
    logic                    count_cyc;
    logic                    pre_run;
    logic                    pre_wrap;
    logic                    tick;
    logic signed [PRE_W-1:0] pre_q;
    logic [CNT_W-1:0]        cnt_q;

    // Qualify a counting cycle, then choose the tick source by mode.
    always_comb begin
        count_cyc = cyc_en && active && ctrl_q.enable && !wr_en;
        pre_run   = count_cyc && !ctrl_q.cyc_mode;
        tick      = count_cyc && (ctrl_q.cyc_mode || pre_wrap);
    end

    irqt_regs #(.CNT_W(CNT_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .rld_q   (rld_q),
        .ctrl_q  (ctrl_q),
        .load_p  (load_p),
        .clr_p   (clr_p)
    );

    irqt_prescale #(.PRE_W(PRE_W), .PERIOD(PERIOD), .STEP(STEP)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load_p),
        .run   (pre_run),
        .pre_q (pre_q),
        .wrap  (pre_wrap)
    );

    irqt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load_p),
        .tick  (tick),
        .clr   (clr_p),
        .rld   (rld_q),
        .cnt_q (cnt_q),
        .irq_q (irq)
    );

endmodule

// File: rtl/irqt_chk.sv
// Assertion checker for the prescaled interrupt timer, bound to the top.
// Assumes a synchronous reset that holds through the first clock edge.
module irqt_chk #(
    parameter int CNT_W  = 8,
    parameter int PRE_W  = 10,
    parameter int PERIOD = 341
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    cyc_en,
    input logic                    active,
    input logic                    wr_en,
    input logic [1:0]              wr_sel,
    input logic                    enable,
    input logic                    cyc_mode,
    input logic [CNT_W-1:0]        cnt,
    input logic signed [PRE_W-1:0] pre,
    input logic                    irq
);
    // R7
    irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(cnt) == {CNT_W{1'b1}});

    // R3
    irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel[1]) |=> !irq);

    // R8
    gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !wr_en) |=> ($stable(cnt) && $stable(pre)));

    // R9
    write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel != 2'd2) |=> ($stable(cnt) && $stable(pre)));

    // R6
    pre_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pre >= 0) && (pre <= PERIOD));

    // R5
    cyc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_en && active && enable && cyc_mode && !wr_en && cnt != {CNT_W{1'b1}})
        |=> cnt == $past(cnt) + CNT_W'(1));

endmodule

bind irq_tick_timer irqt_chk #(.CNT_W(CNT_W), .PRE_W(PRE_W), .PERIOD(PERIOD)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cyc_en   (cyc_en),
    .active   (active),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .enable   (ctrl_q.enable),
    .cyc_mode (ctrl_q.cyc_mode),
    .cnt      (cnt_q),
    .pre      (pre_q),
    .irq      (irq)
);

// File: tb/sim_irq_tick_timer.sv
module sim_irq_tick_timer;
    localparam int CLK_PERIOD = 10;
    localparam int WD_LIMIT   = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cyc_en = 1'b0;
    logic       active = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic       irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // Bench model of the timer.
    bit [7:0] m_rld, m_cnt;
    bit [2:0] m_ctrl;
    int       m_pre;
    bit       m_irq;

    irq_tick_timer u0 (
        .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .active(active),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(string tag, logic got, logic exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: irq got %0b expected %0b", tag, got, exp);
        end
    endtask

    task automatic model_reset();
        m_rld = 0; m_cnt = 0; m_ctrl = 0; m_pre = 0; m_irq = 0;
    endtask

    task automatic model_step(bit we, bit [1:0] sel, bit [7:0] d, bit ce, bit act);
        bit fire;
        if (we) begin
            case (sel)
                2'd0: m_rld = {m_rld[7:4], d[3:0]};
                2'd1: m_rld = {d[3:0], m_rld[3:0]};
                2'd2: begin
                    m_ctrl = d[2:0];
                    m_irq  = 0;
                    if (d[1]) begin m_cnt = m_rld; m_pre = 341; end
                end
                default: begin m_irq = 0; m_ctrl[1] = m_ctrl[0]; end
            endcase
        end else if (ce && act && m_ctrl[1]) begin
            fire = 0;
            if (m_ctrl[2]) fire = 1;
            else begin
                m_pre -= 3;
                if (m_pre <= 0) begin m_pre += 341; fire = 1; end
            end
            if (fire) begin
                if (m_cnt == 8'hFF) begin m_cnt = m_rld; m_irq = 1; end
                else m_cnt++;
            end
        end
    endtask

    // One clock: drive at the falling edge, update the model at the rising edge, sample at the next falling edge.
    task automatic cyc(bit we, bit [1:0] sel, bit [7:0] d, bit ce, bit act);
        wr_en = we; wr_sel = sel; wr_data = d; cyc_en = ce; active = act;
        @(posedge clk);
        model_step(we, sel, d, ce, act);
        @(negedge clk);
    endtask

    task automatic wr(bit [1:0] sel, bit [7:0] d);
        cyc(1, sel, d, 1, 1);
    endtask

    task automatic run(int n, bit ce, bit act);
        for (int i = 0; i < n; i++) cyc(0, 2'd0, 8'd0, ce, act);
    endtask

    task automatic finish_up();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        int cnt = 0;
        forever begin
            @(posedge clk);
            cnt++;
            if (cnt > WD_LIMIT && !done) begin
                n_chk++; n_bad++;
                $display("FAIL watchdog: got timeout expected completion");
                finish_up();
            end
        end
    end

    initial begin
        void'($urandom(32'h1234_5678));
        model_reset();
        @(negedge clk);
        run(3, 0, 0);
        rst_n = 1'b1;
        // R1: reset leaves irq low; control is zero so nothing counts
        chk("R1 reset irq", irq, 1'b0);
        run(20, 1, 1);
        chk("R1 idle after reset", irq, 1'b0);

        // R2 R3 R5 R7: reload 0xFE, cycle mode, wrap after two cycles
        wr(2'd0, 8'hAE);   // low nibble E
        wr(2'd1, 8'h5F);   // high nibble F
        wr(2'd2, 8'h06);
        run(1, 1, 1);
        chk("R5 one cycle no wrap", irq, 1'b0);
        run(1, 1, 1);
        chk("R7 wrap sets irq", irq, 1'b1);
        run(5, 1, 1);
        chk("R7 irq holds", irq, 1'b1);
        wr(2'd3, 8'h00);
        chk("R4 ack clears irq", irq, 1'b0);
        // R2: reload 0xFE from the nibbles, second wrap after 0xFE,0xFF -> 2 more cycles (ack copied bit0=0 so enable off)
        run(4, 1, 1);
        chk("R4 ack copied re-enable 0 into enable", irq, 1'b0);

        // R8: gate low holds the counter
        wr(2'd2, 8'h06);
        run(10, 1, 0);
        chk("R8 gate low holds", irq, 1'b0);
        run(10, 0, 1);
        chk("R8 cyc_en low holds", irq, 1'b0);
        run(1, 1, 1);
        chk("R8 first active cycle", irq, 1'b0);
        run(1, 1, 1);
        chk("R8 wrap after gate", irq, 1'b1);

        // R9: writes to the reload register do not count
        wr(2'd2, 8'h06);
        chk("R3 control write clears irq", irq, 1'b0);
        for (int i = 0; i < 5; i++) wr(2'd0, 8'h0E);
        run(1, 1, 1);
        chk("R9 no advance during writes", irq, 1'b0);
        run(1, 1, 1);
        chk("R9 wrap after writes", irq, 1'b1);

        // R4: disabled with re-enable set; acknowledge turns counting on
        wr(2'd0, 8'h0F);   // reload 0xFF
        wr(2'd2, 8'h06);   // counter = 0xFF
        wr(2'd2, 8'h05);   // enable off, re-enable on, no load
        run(5, 1, 1);
        chk("R8 enable clear holds", irq, 1'b0);
        wr(2'd3, 8'h00);
        run(1, 1, 1);
        chk("R4 ack enables counting", irq, 1'b1);
        wr(2'd3, 8'h00);
        chk("R4 second ack clears", irq, 1'b0);

        // R6: line mode, counter 0xFF, wrap on the 114th cycle
        wr(2'd2, 8'h02);
        run(113, 1, 1);
        chk("R6 no wrap at 113", irq, 1'b0);
        run(1, 1, 1);
        chk("R6 wrap at 114", irq, 1'b1);
        // R6: next wrap after 340 -> 0xFF..., the prescaler is 340 and the counter is 0xFF
        wr(2'd3, 8'h00);   // re-enable was 0: enable now off
        wr(2'd2, 8'h03);   // reload counter, prescaler 341, re-enable on
        run(113, 1, 1);
        wr(2'd3, 8'h00);   // keeps enable on, no advance
        chk("R9 ack in line mode", irq, 1'b0);
        run(1, 1, 1);
        chk("R6 wrap after ack", irq, 1'b1);

        // R7: random mix checked against the model
        for (int i = 0; i < 4000; i++) begin
            bit we = ($urandom_range(0, 15) == 0);
            bit [1:0] sel = 2'($urandom_range(0, 3));
            bit [7:0] d = 8'($urandom_range(0, 255));
            if (we && sel == 2'd2 && $urandom_range(0, 1) == 1) d[1] = 1'b1;
            cyc(we, sel, d, $urandom_range(0, 3) != 0, $urandom_range(0, 7) != 0);
            chk("R7 random vs model", irq, m_irq);
        end

        done = 1;
        finish_up();
    end
endmodule